// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Prescaler

This block takes the undivided source clock and produces a divided system clock for the CPU and the synchronous peripherals. The division factor is a power of two from 1 to 256. Software changes it through a small register write port, and a change must first be armed by a separate unlock write. The divider counter runs on the source clock. A newly accepted ratio is applied only when the current output period ends, so the output never shows a runt pulse or an intermediate period shorter than the old or the new period.

The divided clock is formed by gating the source clock with an enable. That enable is registered on the falling source edge. The output is therefore high for half a source period and low for the rest of each divided period. At a division factor of 1 the output equals the source clock. A static enable selects whether the pin carries the divided clock or the normal I/O value. While reset is asserted, the pin is held low in clock-output mode.

Top module: `clk_prescaler`

## Requirements
- R1: With ratio code c (0 to 8, in `wr_data[3:0]`), consecutive rising edges of `clk_div` are exactly 2^c source periods apart, and each high phase lasts half a source period.
- R2: During a ratio change, every interval between rising edges of `clk_div` equals either the old period or the new period, and no high phase is shorter than half a source period.
- R3: A newly accepted ratio first completes a full new-ratio output period no earlier than one new period and no later than one old period plus one new period after the accepting write edge.
- R4: A setting write (`wr_en` high with `wr_data[7]` = 0) that is not armed leaves the setting and the output period unchanged.
- R5: An unlock write (`wr_data[7]` = 1) arms the port for the next four source cycles. The first setting write within that window is accepted. A setting write made later is ignored, and any setting write closes the window.
- R6: Codes 9 to 15 are ignored even when armed. Setting and period stay as they were.
- R7: `rd_data` returns the most recently accepted code in bits 3:0, with zeros above, from the edge that accepted it.
- R8: Reset sets code 0 (divide by 1), and `pin_out` stays low during reset while clock output is enabled.
- R9: With `clk_out_en` high, `pin_out` carries `clk_div`. With it low, `pin_out` follows `io_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Undivided source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Bit 7 unlock, bits 3:0 ratio code |
| rd_data | output | 8 | Accepted ratio code readback |
| clk_out_en | input | 1 | Static clock-to-pin enable |
| io_out | input | 1 | Normal I/O value for the pin |
| clk_div | output | 1 | Divided system clock |
| pin_out | output | 1 | Pin value: divided clock or I/O value |

## Verification
The bench builds the block with its default parameters: a 4-bit code, a maximum code of 8 and a four-cycle unlock window. This covers the whole factor range from 1 to 256. It also covers both edges of the unlock window and all seven reserved codes. A sequence of ratio changes moves both up and down the range, including the extreme jumps 1 to 256 and 256 to 1. Each change measures every rising-edge interval against the old and new periods and times the first full new period against the write.

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int CODE_W     = 4,
  parameter int MAX_CODE   = 8,
  parameter int UNLOCK_WIN = 4,
  parameter int DATA_W     = 8
) (
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              clk_out_en,
  input  logic              io_out,
  output logic              clk_div,
  output logic              pin_out
);
  localparam int CNT_W  = (MAX_CODE > 0) ? MAX_CODE : 1;
  localparam int WIN_W  = $clog2(UNLOCK_WIN + 1);
  localparam int ARM_BIT = DATA_W - 1;

  logic [CODE_W-1:0] sel_code, act_code;
  logic              pending;
  logic [CNT_W-1:0]  cnt, lim;
  logic [CNT_W:0]    span;
  logic [WIN_W-1:0]  win;
  logic              en_q;

  wire               arm_wr  = wr_en &  wr_data[ARM_BIT];
  wire               set_wr  = wr_en & ~wr_data[ARM_BIT];
  wire [CODE_W-1:0]  wr_code = wr_data[CODE_W-1:0];
  wire               code_ok = (wr_code <= CODE_W'(MAX_CODE));
  wire               accept  = set_wr & (win != '0) & code_ok;

  assign span = (CNT_W+1)'(1) << act_code;
  assign lim  = CNT_W'(span - 1'b1);
  wire   wrap = (cnt == lim);

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n)                 win <= '0;
    else if (arm_wr)            win <= WIN_W'(UNLOCK_WIN);
    else if (set_wr)            win <= '0;
    else if (win != '0)         win <= win - 1'b1;
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      sel_code <= '0;
      pending  <= 1'b0;
    end else if (accept) begin
      sel_code <= wr_code;
      pending  <= 1'b1;
    end else if (pending && wrap) begin
      pending  <= 1'b0;
    end
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= '0;
      cnt      <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (pending && wrap) act_code <= sel_code;
    end
  end

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= wrap;
  end

  assign clk_div = clk_src & en_q;
  assign pin_out = clk_out_en ? (clk_div & rst_n) : io_out;
  assign rd_data = DATA_W'(sel_code);
endmodule

module clk_prescaler_chk #(
  parameter int CODE_W     = 4,
  parameter int MAX_CODE   = 8,
  parameter int UNLOCK_WIN = 4,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int WIN_W      = 3
) (
  input logic              clk_src,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [CODE_W-1:0] sel_code,
  input logic [CODE_W-1:0] act_code,
  input logic              pending,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  lim,
  input logic [WIN_W-1:0]  win,
  input logic              clk_out_en,
  input logic              pin_out
);
  AST_CNT_BOUND: assert property (@(posedge clk_src) disable iff (!rst_n)
    cnt <= lim); // R1
  AST_HOLD_MID_PERIOD: assert property (@(posedge clk_src) disable iff (!rst_n)
    (cnt != lim) |=> $stable(act_code)); // R2
  AST_SWITCH_AT_END: assert property (@(posedge clk_src) disable iff (!rst_n)
    (pending && cnt == lim) |=> (act_code == $past(sel_code) && cnt == '0)); // R3
  AST_UNARMED_IGNORED: assert property (@(posedge clk_src) disable iff (!rst_n)
    (wr_en && !wr_data[DATA_W-1] && win == '0) |=> $stable(rd_data)); // R4
  AST_WIN_LIMIT: assert property (@(posedge clk_src) disable iff (!rst_n)
    win <= WIN_W'(UNLOCK_WIN)); // R5
  AST_RESERVED_IGNORED: assert property (@(posedge clk_src) disable iff (!rst_n)
    (wr_en && !wr_data[DATA_W-1] && wr_data[CODE_W-1:0] > CODE_W'(MAX_CODE)) |=> $stable(rd_data)); // R6
  AST_CODE_LEGAL: assert property (@(posedge clk_src) disable iff (!rst_n)
    sel_code <= CODE_W'(MAX_CODE)); // R7
  always @(negedge clk_src) begin
    if (!rst_n) AST_PIN_LOW_IN_RESET: assert (!clk_out_en || !pin_out); // R8
  end
endmodule

bind clk_prescaler clk_prescaler_chk #(
  .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .UNLOCK_WIN(UNLOCK_WIN),
  .DATA_W(DATA_W), .CNT_W(CNT_W), .WIN_W(WIN_W)
) u_chk (
  .clk_src(clk_src), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .sel_code(sel_code), .act_code(act_code),
  .pending(pending), .cnt(cnt), .lim(lim), .win(win),
  .clk_out_en(clk_out_en), .pin_out(pin_out)
);

// File: tb/clk_prescaler_tb.sv
`timescale 1ns/1ns
module clk_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       clk_out_en = 1'b1;
  logic       io_out = 1'b1;
  logic       clk_div;
  logic       pin_out;

  int  checks = 0;
  int  fails = 0;
  int  glitch_bad = 0;
  time rise_t = 0;
  time last_wr_t = 0;
  int  cur_code = 0;

  localparam int NSEQ = 12;
  localparam int SEQ [NSEQ] = '{3, 8, 0, 5, 1, 7, 2, 6, 8, 4, 0, 8};

  always #5 clk = ~clk;

  clk_prescaler u_dut (
    .clk_src(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_out_en(clk_out_en), .io_out(io_out),
    .clk_div(clk_div), .pin_out(pin_out)
  );

  always @(posedge clk_div) rise_t = $time;
  always @(negedge clk_div) if (rst_n && ($time - rise_t) != 5) glitch_bad++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    last_wr_t = $time;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic measure(input longint exp, input string req);
    time t0;
    @(posedge clk_div); t0 = $time;
    @(posedge clk_div);
    chk(($time - t0) == exp, req, "period", $time - t0, exp);
  endtask

  task automatic step(input int code);
    longint pold, pnew, iv;
    time prev, tw, first_new;
    int newrun, bad;
    pold = (64'd1 << cur_code) * 10;
    pnew = (64'd1 << code) * 10;
    wr(8'h80);
    wr(8'(code));
    tw = last_wr_t;
    chk(rd_data == 8'(code), "R7", "readback", rd_data, code);
    @(posedge clk_div); prev = $time;
    newrun = 0; bad = 0; first_new = 0;
    for (int i = 0; i < 40 && newrun < 2; i++) begin
      @(posedge clk_div);
      iv = $time - prev; prev = $time;
      if (iv != pold && iv != pnew) bad++;
      if (iv == pnew) begin
        if (newrun == 0) first_new = $time;
        newrun++;
      end else newrun = 0;
    end
    chk(bad == 0, "R2", "odd intervals", bad, 0);
    chk(newrun >= 2, "R1", "new period runs", newrun, 2);
    chk((first_new - tw) <= pold + pnew && (first_new - tw) >= pnew, "R3",
        "switch latency", first_new - tw, pold + pnew);
    cur_code = code;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_data == 8'd0, "R8", "reset code", rd_data, 0);
    @(posedge clk); #1;
    chk(pin_out == 1'b0, "R8", "pin in reset", pin_out, 0);
    @(negedge clk); rst_n = 1'b1;
    measure(10, "R1");
    @(posedge clk); #1;
    chk(pin_out == 1'b1, "R9", "pin high phase", pin_out, 1);
    @(negedge clk); #1;
    chk(pin_out == 1'b0, "R9", "pin low phase", pin_out, 0);

    for (int s = 0; s < NSEQ; s++) step(SEQ[s]);
    step(0);

    // R4: unarmed write
    wr(8'h03);
    chk(rd_data == 8'd0, "R4", "unarmed code", rd_data, 0);
    measure(10, "R4");

    // R5: window edges
    wr(8'h80); repeat (3) @(negedge clk); wr(8'h02);
    chk(rd_data == 8'd0, "R5", "late write", rd_data, 0);
    measure(10, "R5");
    wr(8'h80); repeat (2) @(negedge clk); wr(8'h01);
    chk(rd_data == 8'd1, "R5", "in-window write", rd_data, 1);
    measure(20, "R5");
    measure(20, "R5");

    // R6: reserved codes
    for (int c = 9; c < 16; c++) begin
      wr(8'h80); wr(8'(c));
      chk(rd_data == 8'd1, "R6", "reserved code", rd_data, 1);
    end
    measure(20, "R6");

    // R9: pin follows io_out when disabled
    clk_out_en = 1'b0; io_out = 1'b1;
    @(posedge clk); #1;
    chk(pin_out == 1'b1, "R9", "io high", pin_out, 1);
    io_out = 1'b0;
    @(posedge clk); #1;
    chk(pin_out == 1'b0, "R9", "io low", pin_out, 0);

    // R8: reset mid-run
    clk_out_en = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk(pin_out == 1'b0, "R8", "pin in reset", pin_out, 0);
    chk(rd_data == 8'd0, "R8", "code after reset", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;
    measure(10, "R8");

    chk(glitch_bad == 0, "R2", "short high phases", glitch_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule